// File: doc/BRIEF.md
# Chained Multiply-Add Extended Unit

This block multiplies two 64-bit limbs and adds a third limb. It returns the whole 128-bit result as two 64-bit words. The low word is the result limb. The high word is the carry limb, which software feeds back as the addend of the next operation. With this feedback, a run of operations that starts from a zero addend multiplies a big integer of any length by one 64-bit scalar, limb by limb, and keeps no other state between the steps.

There are two arithmetic modes. In unsigned mode all three operands are unsigned. In mixed mode the first factor is unsigned, while the second factor and the addend are two's complement signed values. The block uses a shift-add datapath that handles `STEP_BITS` multiplier bits per cycle. An operation starts with a one-cycle `start` pulse and ends with a one-cycle `done` pulse. The block produces no flags of any kind.

Top module: `cmae_unit`

## Requirements
- R1: With `mode`=0, the block treats a, b and c as unsigned. `{hi,lo}` equals a*b + c computed exactly in 128 bits.
- R2: With `mode`=1, a is unsigned and b and c are two's complement. `{hi,lo}` equals the 128-bit two's complement of a*b + c.
- R3: With `mode`=0 and all three operands all-ones, the result is hi = all-ones and lo = 0. The unsigned sum never exceeds 128 bits.
- R4: For the same a, b and c, `lo` is identical in both modes. Only `hi` depends on the mode.
- R5: A chain of operations that passes each `hi` in as the next `c`, starting from c=0, gives the limbs of a multi-limb integer times a 64-bit scalar. The final `hi` is the top limb.
- R6: `done` rises exactly STEPS+1 cycles after the clock edge that samples `start`, where STEPS = 64/STEP_BITS (33 cycles at the default of 2). `done` stays high for exactly one cycle.
- R7: After reset, lo, hi and done are 0. lo and hi change only in the cycle where done is high, and otherwise hold their values.
- R8: A `start` pulse while an operation is running has no effect. The running result and its timing are unchanged.
- R9: In mixed mode, b = 0x8000_0000_0000_0000 (the most negative value) gives the exact product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Samples the operands and mode when the block is idle |
| mode | input | 1 | 0 = unsigned, 1 = unsigned a times signed b plus signed c |
| a | input | 64 | First factor, unsigned |
| b | input | 64 | Second factor |
| c | input | 64 | Addend, or the carry limb of the previous step |
| lo | output | 64 | Low 64 bits of the result |
| hi | output | 64 | High 64 bits of the result, which is the carry limb |
| done | output | 1 | One-cycle pulse that marks lo and hi as new |

## Verification
The bench drives the all-ones unsigned case. A design that drops the top carry of the 128-bit sum gives a wrong `hi` there, and a design that sign-extends c in unsigned mode does too. In mixed mode the bench tries a negative b with a positive c, a negative c with a zero product, and the most negative b. A design that extends b or c the wrong way, or that gets the magnitude of the most negative b wrong, produces the wrong high word. The bench also runs a four-limb chain against a wide integer product, which catches any error in how the carry is passed on. Finally it pulses `start` in the middle of an operation, so a design that restarts or takes in the new operands returns a wrong result or a late `done`.

// File: rtl/cmae_pkg.sv
package cmae_pkg;

    localparam int LIMB_W = 64;
    localparam int WIDE_W = 2 * LIMB_W;

    typedef enum logic [0:0] {
        MODE_UNSIGNED = 1'b0,
        MODE_MIXED    = 1'b1
    } mac_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mac_state_e;

    // Operands for the iterative multiplier
    typedef struct packed {
        logic [LIMB_W-1:0] mcand;
        logic [LIMB_W-1:0] mplier;
    } mul_in_t;

    // Operands for the final sign fix and addend stage
    typedef struct packed {
        logic              negate;
        logic [WIDE_W-1:0] addend;
        mac_mode_e         mode;
    } fix_in_t;

    typedef struct packed {
        logic [LIMB_W-1:0] hi;
        logic [LIMB_W-1:0] lo;
    } mac_result_t;

    function automatic logic [LIMB_W-1:0] limb_negate(input logic [LIMB_W-1:0] v);
        return ~v + LIMB_W'(1);
    endfunction

    function automatic logic [WIDE_W-1:0] wide_negate(input logic [WIDE_W-1:0] v);
        return ~v + WIDE_W'(1);
    endfunction

endpackage

// File: rtl/cmae_prep.sv
module cmae_prep
    import cmae_pkg::*;
(
    input  mac_mode_e         mode,
    input  logic [LIMB_W-1:0] a,
    input  logic [LIMB_W-1:0] b,
    input  logic [LIMB_W-1:0] c,
    output mul_in_t           mul_in,
    output fix_in_t           fix_in
);
    logic b_neg;

    always_comb begin
        b_neg         = (mode == MODE_MIXED) && b[LIMB_W-1];
        mul_in.mcand  = a;
        // In mixed mode a negative b is multiplied by its magnitude
        mul_in.mplier = b_neg ? limb_negate(b) : b;
        fix_in.negate = b_neg;
        fix_in.mode   = mode;
        if (mode == MODE_MIXED)
            fix_in.addend = {{LIMB_W{c[LIMB_W-1]}}, c};
        else
            fix_in.addend = {{LIMB_W{1'b0}}, c};
    end
endmodule

// File: rtl/cmae_shift_add.sv
module cmae_shift_add
    import cmae_pkg::*;
#(
    parameter int STEP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  mul_in_t           mul_in,
    output logic [WIDE_W-1:0] prod,
    output logic              mplier_empty
);
    logic [WIDE_W-1:0] mcand_q;
    logic [LIMB_W-1:0] mplier_q;
    logic [WIDE_W-1:0] acc_q;
    logic [WIDE_W-1:0] acc_n;

    // Add the partial products for STEP_BITS multiplier bits
    always_comb begin
        acc_n = acc_q;
        for (int k = 0; k < STEP_BITS; k++) begin
            if (mplier_q[k])
                acc_n = acc_n + (mcand_q << k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
        end else if (load) begin
            mcand_q  <= {{LIMB_W{1'b0}}, mul_in.mcand};
            mplier_q <= mul_in.mplier;
            acc_q    <= '0;
        end else if (step) begin
            mcand_q  <= mcand_q << STEP_BITS;
            mplier_q <= mplier_q >> STEP_BITS;
            acc_q    <= acc_n;
        end
    end

    assign prod         = acc_q;
    assign mplier_empty = (mplier_q == '0);

    // R6: the accumulator only grows by partial products while stepping
    a_r6_acc_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(acc_q));
endmodule

// File: rtl/cmae_finish.sv
module cmae_finish
    import cmae_pkg::*;
(
    input  logic [WIDE_W-1:0] prod,
    input  fix_in_t           fix_in,
    output mac_result_t       result,
    output logic              carry_out
);
    logic [WIDE_W-1:0] signed_prod;
    logic [WIDE_W:0]   sum;

    always_comb begin
        signed_prod = fix_in.negate ? wide_negate(prod) : prod;
        sum         = {1'b0, signed_prod} + {1'b0, fix_in.addend};
        result.lo   = sum[LIMB_W-1:0];
        result.hi   = sum[WIDE_W-1:LIMB_W];
        carry_out   = sum[WIDE_W];
    end
endmodule

// File: rtl/cmae_unit.sv
module cmae_unit
    import cmae_pkg::*;
#(
    parameter int STEP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [LIMB_W-1:0] a,
    input  logic [LIMB_W-1:0] b,
    input  logic [LIMB_W-1:0] c,
    output logic [LIMB_W-1:0] lo,
    output logic [LIMB_W-1:0] hi,
    output logic              done
);
    localparam int STEPS = LIMB_W / STEP_BITS;
    localparam int CNT_W = $clog2(STEPS) + 1;

    mac_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    fix_in_t           fix_q;
    mul_in_t           mul_in;
    fix_in_t           fix_in;
    logic [WIDE_W-1:0] prod;
    logic              mplier_empty;
    mac_result_t       fin_res;
    logic              fin_carry;
    logic              accept;
    logic              stepping;

    assign accept   = (state_q == ST_IDLE) && start;
    assign stepping = (state_q == ST_RUN);

    cmae_prep u_prep (
        .mode   (mac_mode_e'(mode)),
        .a      (a),
        .b      (b),
        .c      (c),
        .mul_in (mul_in),
        .fix_in (fix_in)
    );

    cmae_shift_add #(.STEP_BITS(STEP_BITS)) u_mul (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .step         (stepping),
        .mul_in       (mul_in),
        .prod         (prod),
        .mplier_empty (mplier_empty)
    );

    cmae_finish u_fin (
        .prod      (prod),
        .fix_in    (fix_q),
        .result    (fin_res),
        .carry_out (fin_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            fix_q   <= '0;
            lo      <= '0;
            hi      <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        fix_q   <= fix_in;
                        cnt_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == CNT_W'(STEPS - 1))
                        state_q <= ST_FIN;
                end
                ST_FIN: begin
                    lo      <= fin_res.lo;
                    hi      <= fin_res.hi;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: the unsigned sum of product and addend never carries out of 128 bits
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIN && fix_q.mode == MODE_UNSIGNED) |-> !fin_carry);

    // R6: every multiplier bit has been consumed before the result is formed
    a_r6_mplier_drained: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIN) |-> mplier_empty);

    // R6: done lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: the results move only together with done
    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(lo) && $stable(hi)));

    // R8: captured operands stay fixed while an operation is in flight
    a_r8_ignore_busy_start: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(fix_q));
endmodule

// File: tb/test_cmae_unit.sv
module test_cmae_unit;
    localparam int STEP_BITS = 2;
    localparam int STEPS     = 64 / STEP_BITS;
    localparam int LAT       = STEPS + 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        mode;
    logic [63:0] a, b, c;
    logic [63:0] lo, hi;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    cmae_unit #(.STEP_BITS(STEP_BITS)) i_cmae_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .a(a), .b(b), .c(c), .lo(lo), .hi(hi), .done(done)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_errors++;
            $display("FAIL R6 watchdog expired: got %0d cycles exp < 100000", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got %h exp %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] ref_mac(input bit m, input logic [63:0] x,
                                            input logic [63:0] y, input logic [63:0] z);
        logic signed [127:0] sx, sy, sz;
        if (m) begin
            sx = {64'd0, x};
            sy = {{64{y[63]}}, y};
            sz = {{64{z[63]}}, z};
            return sx * sy + sz;
        end
        return {64'd0, x} * {64'd0, y} + {64'd0, z};
    endfunction

    // Runs one operation, checks timing and holding every cycle, then the value
    task automatic run_op(input bit m, input logic [63:0] x, input logic [63:0] y,
                          input logic [63:0] z, input bit inject, input string req,
                          output logic [127:0] res);
        logic [127:0] prev;
        logic [127:0] exp;
        bit timing_ok = 1'b1;
        bit hold_ok   = 1'b1;
        exp  = ref_mac(m, x, y, z);
        prev = {hi, lo};
        @(negedge clk);
        mode = m; a = x; b = y; c = z; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk);
            if (k < LAT) begin
                if (done !== 1'b0) timing_ok = 1'b0;
                if ({hi, lo} !== prev) hold_ok = 1'b0;
            end else if (done !== 1'b1) begin
                timing_ok = 1'b0;
            end
            if (inject && k == 5) begin
                start = 1'b1; mode = ~m; a = ~x; b = 64'h1234; c = ~z;
            end else begin
                start = 1'b0;
            end
        end
        check(timing_ok, "R6 done at STEPS+1", {127'd0, done}, 128'd1);
        check(hold_ok, "R7 hold while running", {hi, lo}, prev);
        check({hi, lo} === exp, req, {hi, lo}, exp);
        res = {hi, lo};
        @(negedge clk);
        check(done === 1'b0, "R6 done single cycle", {127'd0, done}, 128'd0);
    endtask

    initial begin
        logic [127:0] r, r2;
        logic [255:0] vec;
        logic [319:0] big;
        logic [63:0]  carry;
        logic [63:0]  scal;
        bit           chain_ok;

        rst = 1'b1; start = 1'b0; mode = 1'b0; a = '0; b = '0; c = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({hi, lo, done} === 129'd0, "R7 reset state", {hi, lo}, 128'd0);

        run_op(1'b0, 64'd3, 64'd5, 64'd7, 1'b0, "R1 small unsigned", r);
        run_op(1'b0, 64'hDEAD_BEEF_0123_4567, 64'hFEDC_BA98_7654_3210,
               64'h8000_0000_0000_0001, 1'b0, "R1 wide unsigned", r);
        run_op(1'b0, '1, '1, '1, 1'b0, "R3 all-ones unsigned", r);
        check(r === {64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, "R3 exact value", r,
              {64'hFFFF_FFFF_FFFF_FFFF, 64'd0});

        run_op(1'b1, 64'h0000_0001_0000_0003, 64'hFFFF_FFFF_FFFF_FFFE,
               64'd100, 1'b0, "R2 negative b", r);
        run_op(1'b1, 64'd0, 64'd9, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, "R2 negative c", r);
        check(r[127:64] === '1, "R2 negative c high word", r, {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0});
        run_op(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
               64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R9 most negative b", r);
        run_op(1'b1, 64'hCAFE_0000_1111_2222, 64'h0123_4567_89AB_CDEF,
               64'h8765_4321_0000_0001, 1'b0, "R2 positive b negative c", r);

        // R4: same operands in both modes give the same low word
        run_op(1'b0, 64'h9999_AAAA_BBBB_CCCC, 64'hF000_0000_0000_0011,
               64'h8000_0000_0000_0005, 1'b0, "R1 for R4 pair", r);
        run_op(1'b1, 64'h9999_AAAA_BBBB_CCCC, 64'hF000_0000_0000_0011,
               64'h8000_0000_0000_0005, 1'b0, "R2 for R4 pair", r2);
        check(r[63:0] === r2[63:0], "R4 low word mode independent", r2, r);
        check(r[127:64] !== r2[127:64], "R4 high word differs", r2, r);

        // R8: a start pulse in mid-run is ignored
        run_op(1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 64'h1111_2222_3333_4444,
               64'd42, 1'b1, "R8 start while busy ignored", r);

        // R5: four-limb integer times a scalar through the carry chain
        vec  = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
                64'h8000_0000_0000_0000, 64'hFFFF_FFFF_0000_0001};
        scal = 64'hFEDC_BA98_7654_3211;
        big  = {64'd0, vec} * {256'd0, scal};
        carry = '0;
        chain_ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            run_op(1'b0, vec[64*i +: 64], scal, carry, 1'b0, "R5 chain step", r);
            if (r[63:0] !== big[64*i +: 64]) chain_ok = 1'b0;
            carry = r[127:64];
        end
        check(chain_ok, "R5 chain limbs", {64'd0, r[63:0]}, {64'd0, big[191:128]});
        check(carry === big[319:256], "R5 chain top limb", {64'd0, carry}, {64'd0, big[319:256]});

        // R7: outputs hold across idle cycles
        r = {hi, lo};
        repeat (6) @(negedge clk);
        check({hi, lo} === r && done === 1'b0, "R7 hold while idle", {hi, lo}, r);

        finish_run();
    end
endmodule